// File: doc/BRIEF.md
# Hot-Swap Local Reset Sequencer

This block drives the active-low local bus reset of a plug-in card that can be inserted into a live backplane. It takes digital comparator results for the host-side and card-side supply monitors, the board-select inputs, a power-enable pin and the incoming backplane reset. It keeps the local reset asserted until every power-up condition is true at once and a power-up delay has run out. Only then does it release the reset, which is the last step of the power-up sequence. All of these inputs are asynchronous, and each one passes through a two-flop synchronizer before it is used.

Once the reset is released, the block tracks the incoming backplane reset. A low level on that input has to persist for `FILT_LEN` consecutive samples before it counts; with a 100 MHz clock and the default of 4, that is about 40 ns. A qualified low starts a new reset cycle. The cycle lasts `PWRUP_CYC` clock cycles, or lasts until the incoming reset returns high, whichever takes longer. If any supply, select or enable condition drops, the local reset is asserted again after a fixed latency and the power-up delay starts over.

The state machine has five states:
- `ST_HOLD` waits for all conditions.
- `ST_DELAY` counts the power-up delay.
- `ST_RUN` has the reset released.
- `ST_PULSE` enforces the minimum stretch.
- `ST_FOLLOW` holds the reset while the incoming reset stays low.

The transitions are:
- HOLD to DELAY when all conditions are met.
- DELAY back to HOLD when any condition fails.
- DELAY to RUN when the timer reaches zero.
- RUN to HOLD on a power-condition failure.
- RUN to PULSE on a filtered incoming-reset low.
- PULSE to RUN, or PULSE to FOLLOW, when the timer reaches zero, depending on the incoming-reset level.
- FOLLOW to RUN when the incoming reset returns high.
- PULSE or FOLLOW to HOLD on a power-condition failure.

Top module: `hotswap_reset_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `local_rst_n_o` is 0 (reset asserted) and `in_reset_o` is 1.
- R2: The reset is released only when all of the following hold together: both `host_ok_i` bits are 1 (supply at or above trip), both `card_ok_i` bits are 1, every `bdsel_n_i` bit is 0, `pwr_en_i` is 1, and `bus_rst_n_i` is 1. If the last of these becomes true between two clock edges, `local_rst_n_o` rises on rising edge `PWRUP_CYC+3` after that change.
- R3: If any release condition goes false during the power-up delay, the block returns to waiting. The full delay then restarts from the moment the conditions are met again.
- R4: While the reset is released, a card supply monitor bit dropping to 0 asserts the reset on exactly the third rising edge after the change. Any other power condition failing has the same effect.
- R5: A low on `bus_rst_n_i` that lasts fewer than `FILT_LEN` rising edges leaves the released reset unchanged.
- R6: A low on `bus_rst_n_i` that lasts `FILT_LEN` rising edges asserts the reset on edge `FILT_LEN+3` after the fall. If the input has already returned high, the reset then stays asserted for exactly `PWRUP_CYC` cycles.
- R7: A low on `bus_rst_n_i` that lasts longer than `PWRUP_CYC` keeps the reset asserted until the input returns high. The reset is released on the third rising edge after the rise.
- R8: `in_reset_o` is always the inverse of `local_rst_n_o`.
- R9: While `bus_rst_n_i` is low, the reset is not released, even when every other condition is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low block reset |
| host_ok_i | input | 2 | Host supply comparator results; 1 means at or above trip |
| card_ok_i | input | 2 | Card supply comparator results; 1 means at or above trip |
| bdsel_n_i | input | BDSEL_W | Board-select inputs; active low |
| pwr_en_i | input | 1 | Power-enable pin; active high |
| bus_rst_n_i | input | 1 | Incoming backplane reset; active low |
| local_rst_n_o | output | 1 | Local bus reset; active low |
| in_reset_o | output | 1 | High while the local reset is asserted |

## Verification
The hardest case to reach is a condition that fails during the power-up delay, because the block looks identical from its ports whether the delay restarted or simply carried on. The stimulus first releases the reset and then drops a card monitor. It restores the monitor, and partway through the new delay it deasserts board select for two cycles. The bench then checks that release arrives a full `PWRUP_CYC+3` edges after the second restore; a release timed from the first restore would come earlier. The filter boundary is hit with incoming-reset pulses of exactly `FILT_LEN-1` and `FILT_LEN` cycles. The two stretch outcomes are covered by pulses much shorter than, and longer than, the delay.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_DELAY  = 3'd1,
        ST_RUN    = 3'd2,
        ST_PULSE  = 3'd3,
        ST_FOLLOW = 3'd4
    } hsr_state_t;
endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/hsr_glitch_filter.sv
module hsr_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic low_ok
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CMAX = CW'(FILT_LEN);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (din_n) begin
            run_q <= '0;
        end else if (run_q != CMAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign low_ok = (run_q == CMAX);

    // R5: a qualified low requires the last sample to have been low
    assert_filter_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_ok |-> !$past(din_n));

    // R5: run counter saturates at the filter length
    assert_filter_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CMAX);
endmodule

// File: rtl/hsr_delay_timer.sv
module hsr_delay_timer #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int TW = (CYC < 2) ? 1 : $clog2(CYC);
    localparam logic [TW-1:0] TOP = TW'(CYC - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= TOP;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R2: a freshly loaded count is never already expired unless CYC is 1
    assert_timer_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == TOP));
endmodule

// File: rtl/hotswap_reset_seq.sv
module hotswap_reset_seq #(
    parameter int BDSEL_W   = 2,
    parameter int FILT_LEN  = 4,
    parameter int PWRUP_CYC = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         host_ok_i,
    input  logic [1:0]         card_ok_i,
    input  logic [BDSEL_W-1:0] bdsel_n_i,
    input  logic               pwr_en_i,
    input  logic               bus_rst_n_i,
    output logic               local_rst_n_o,
    output logic               in_reset_o
);
    import hsr_pkg::*;

    localparam int IN_W = 6 + BDSEL_W;
    localparam logic [IN_W-1:0] IN_RST = {2'b00, 2'b00, {BDSEL_W{1'b1}}, 1'b0, 1'b0};
    localparam int HW = $clog2(PWRUP_CYC + 1);
    localparam logic [HW-1:0] HMAX = HW'(PWRUP_CYC);

    logic [IN_W-1:0]    raw_vec;
    logic [IN_W-1:0]    syn_vec;
    logic [1:0]         host_s;
    logic [1:0]         card_s;
    logic [BDSEL_W-1:0] bdsel_s;
    logic               pwren_s;
    logic               bus_s;

    assign raw_vec = {host_ok_i, card_ok_i, bdsel_n_i, pwr_en_i, bus_rst_n_i};

    hsr_sync #(.W(IN_W), .RST_VAL(IN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_vec),
        .dout  (syn_vec)
    );

    assign {host_s, card_s, bdsel_s, pwren_s, bus_s} = syn_vec;

    logic pwr_ok;
    logic all_ok;
    assign pwr_ok = (&host_s) && (&card_s) && (bdsel_s == '0) && pwren_s;
    assign all_ok = pwr_ok && bus_s;

    logic bus_low_q;
    hsr_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (bus_s),
        .low_ok (bus_low_q)
    );

    hsr_state_t state_q, state_d;
    logic tmr_load, tmr_run, tmr_done;

    hsr_delay_timer #(.CYC(PWRUP_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .run     (tmr_run),
        .expired (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (all_ok) begin
                    state_d  = ST_DELAY;
                    tmr_load = 1'b1;
                end
            end
            ST_DELAY: begin
                if (!all_ok)       state_d = ST_HOLD;
                else if (tmr_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!pwr_ok) begin
                    state_d = ST_HOLD;
                end else if (bus_low_q) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                end
            end
            ST_PULSE: begin
                if (!pwr_ok)       state_d = ST_HOLD;
                else if (tmr_done) state_d = bus_s ? ST_RUN : ST_FOLLOW;
            end
            ST_FOLLOW: begin
                if (!pwr_ok)   state_d = ST_HOLD;
                else if (bus_s) state_d = ST_RUN;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        tmr_run       = 1'b0;
        local_rst_n_o = 1'b0;
        unique case (state_q)
            ST_HOLD:   local_rst_n_o = 1'b0;
            ST_DELAY:  tmr_run = 1'b1;
            ST_RUN:    local_rst_n_o = 1'b1;
            ST_PULSE:  tmr_run = 1'b1;
            ST_FOLLOW: local_rst_n_o = 1'b0;
            default:   local_rst_n_o = 1'b0;
        endcase
        in_reset_o = ~local_rst_n_o;
    end

    // length of the current asserted stretch, used by the width check
    logic [HW-1:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              held_q <= '0;
        else if (local_rst_n_o)  held_q <= '0;
        else if (held_q != HMAX) held_q <= held_q + 1'b1;
    end

    // R2: release only follows a cycle in which every condition held
    assert_release_needs_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(local_rst_n_o) |-> $past(all_ok));

    // R4: a power condition failure while released asserts the reset next
    assert_power_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (local_rst_n_o && !pwr_ok) |=> !local_rst_n_o);

    // R6: every asserted stretch lasts at least the delay length
    assert_min_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(local_rst_n_o) |-> (held_q == HMAX));

    // R9: no release while the synchronized incoming reset is low
    assert_bus_low_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!local_rst_n_o && !bus_s) |=> !local_rst_n_o);
endmodule

// File: tb/hotswap_reset_seq_bench.sv
module hotswap_reset_seq_bench;
    localparam int P  = 20;
    localparam int FL = 4;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    host_ok;
    logic [1:0]    card_ok;
    logic [BW-1:0] bdsel_n;
    logic          pwr_en;
    logic          bus_rst_n;
    logic          lrst_n;
    logic          inrst;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hotswap_reset_seq #(.BDSEL_W(BW), .FILT_LEN(FL), .PWRUP_CYC(P)) u_hotswap_reset_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_ok_i     (host_ok),
        .card_ok_i     (card_ok),
        .bdsel_n_i     (bdsel_n),
        .pwr_en_i      (pwr_en),
        .bus_rst_n_i   (bus_rst_n),
        .local_rst_n_o (lrst_n),
        .in_reset_o    (inrst)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_rst(input logic exp, input string req);
        chk(lrst_n === exp, req, int'(lrst_n), int'(exp));
        chk(inrst === ~exp, {req, " (R8)"}, int'(inrst), int'(~exp));
    endtask

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0; host_ok = 2'b00; card_ok = 2'b00; bdsel_n = '1;
        pwr_en = 1'b0; bus_rst_n = 1'b0;
        wn(3);
        expect_rst(1'b0, "R1 during reset");
        rst_n = 1'b1;
        wn(2);
        expect_rst(1'b0, "R1 after reset");
    endtask

    task automatic t_bus_low_hold_R9_then_release_R2();
        host_ok = 2'b11; card_ok = 2'b11; bdsel_n = '0; pwr_en = 1'b1;
        wn(P + 10);
        expect_rst(1'b0, "R9 held while bus reset low");
        bus_rst_n = 1'b1;
        wn(P + 2);
        expect_rst(1'b0, "R2 before delay end");
        wn(1);
        expect_rst(1'b1, "R2 released at P+3");
    endtask

    task automatic t_card_fail_R4_restart_R3();
        card_ok[1] = 1'b0;
        wn(2);
        expect_rst(1'b1, "R4 still released 2 edges");
        wn(1);
        expect_rst(1'b0, "R4 asserted 3rd edge");
        wn(4);
        card_ok[1] = 1'b1;
        wn(10);
        bdsel_n[0] = 1'b1;
        wn(2);
        bdsel_n[0] = 1'b0;
        wn(P + 2);
        expect_rst(1'b0, "R3 delay restarted");
        wn(1);
        expect_rst(1'b1, "R3 release after restarted delay");
    endtask

    task automatic t_glitch_R5();
        bus_rst_n = 1'b0;
        wn(FL - 1);
        bus_rst_n = 1'b1;
        begin
            int lows = 0;
            for (int i = 0; i < 30; i++) begin
                wn(1);
                if (lrst_n !== 1'b1) lows++;
            end
            chk(lows == 0, "R5 short low ignored", lows, 0);
        end
    endtask

    task automatic t_short_pulse_R6();
        bus_rst_n = 1'b0;
        wn(FL);
        bus_rst_n = 1'b1;
        wn(2);
        expect_rst(1'b1, "R6 not yet asserted");
        wn(1);
        expect_rst(1'b0, "R6 asserted FILT+3");
        wn(P - 1);
        expect_rst(1'b0, "R6 stretch held");
        wn(1);
        expect_rst(1'b1, "R6 released after P cycles");
    endtask

    task automatic t_long_pulse_R7();
        bus_rst_n = 1'b0;
        wn(FL + 3 + P + 2);
        expect_rst(1'b0, "R7 follows long low");
        wn(P + 10 - (FL + 3 + P + 2));
        bus_rst_n = 1'b1;
        wn(2);
        expect_rst(1'b0, "R7 still held after rise");
        wn(1);
        expect_rst(1'b1, "R7 released 3rd edge after rise");
    endtask

    task automatic t_pwr_en_R4();
        pwr_en = 1'b0;
        wn(3);
        expect_rst(1'b0, "R4 power enable drop");
    endtask

    initial begin
        wn(1);
        t_reset_R1();
        t_bus_low_hold_R9_then_release_R2();
        t_card_fail_R4_restart_R3();
        t_glitch_R5();
        t_short_pulse_R6();
        t_long_pulse_R7();
        t_pwr_en_R4();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule